// File: doc/BRIEF.md
# Instruction Clock Cost Meter

This block prices each retired instruction in clock cycles. A decode stage hands it one descriptor per instruction: the operation class, the kinds of the destination and source operands, the memory addressing form, whether a displacement is present, whether the operation is word-wide, and the low bit of the memory address. A mode input says whether the external bus is 8 bits or 16 bits wide.

From these inputs the block works out three parts of the cost. The base cost depends on the operation class and the operand kinds. The addressing cost depends on how the memory address is formed. The bus penalty is the extra cost of moving a word over a narrow bus or to an odd address.

All three parts and their sum are registered and shown on the outputs one cycle after the valid strobe. In the same cycle the sum is added to a 32-bit running clock counter. If the block does not recognise a descriptor, it raises a flag, reports zero cost and leaves the counter as it was.

Top module: `instr_clock_meter`

## Requirements
- R1: With `op_add`=0 (move) and operand kinds coded 0 = register, 1 = immediate, 2 = memory, the base cost is: immediate into register 4, register to register 2, memory into register 8, register into memory 9.
- R2: With `op_add`=1 (add), the base cost is: register to register 3, immediate into register 4, memory into register 9, register into memory 16, immediate into memory 17.
- R3: For a memory operand, `addr_form` codes 2 (BX+SI) and 5 (BP+DI) cost 7 addressing clocks, or 11 clocks with a displacement. Codes 3 (BX+DI) and 4 (BP+SI) cost 8 clocks, or 12 clocks with a displacement.
- R4: `addr_form` code 0 (a single register) costs 5 addressing clocks, or 9 clocks with a displacement. Code 1 (direct address) always costs 6 clocks.
- R5: A descriptor with no memory operand has zero addressing clocks and zero penalty clocks.
- R6: With `bus8`=1, a word-wide operation pays 4 penalty clocks for each memory transfer. A plain read or write is one transfer. An add into memory is two transfers and pays 8.
- R7: With `bus8`=0, a word-wide operation pays the penalty only when `addr_odd`=1: 4 clocks per transfer. A byte operation never pays a penalty on either bus.
- R8: One cycle after `in_valid`, `out_valid` is high. In that cycle the outputs hold the three parts of the cost and their sum, `total_clk`.
- R9: After reset the counter is zero. Each accepted descriptor adds `total_clk` to it. The counter holds its value in every cycle that has no strobe.
- R10: `clr` sets the counter to zero on the next edge. This also happens when a strobe arrives in the same cycle.
- R11: The following descriptors are unsupported: an immediate destination, operand kind 3, memory on both sides, a move of an immediate into memory, and a memory operand with `addr_form` 6 or 7. For these the block raises `unsupported`, reports zero for every cost output and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous counter clear |
| in_valid | input | 1 | Descriptor strobe, one cycle per instruction |
| op_add | input | 1 | 0 = move, 1 = add |
| dst_kind | input | 2 | Destination kind: 0 reg, 1 imm, 2 mem, 3 reserved |
| src_kind | input | 2 | Source kind: same coding as dst_kind |
| addr_form | input | 3 | Memory address form, 0..5 |
| has_disp | input | 1 | A displacement is present |
| is_word | input | 1 | Word-wide operation |
| addr_odd | input | 1 | Low bit of the memory address |
| bus8 | input | 1 | 1 = 8-bit external bus, 0 = 16-bit |
| out_valid | output | 1 | Cost outputs are valid |
| base_clk | output | CLK_W | Base clocks |
| ea_clk | output | CLK_W | Addressing clocks |
| pen_clk | output | CLK_W | Bus penalty clocks |
| total_clk | output | CLK_W | Sum of the three parts |
| unsupported | output | 1 | Descriptor not recognised |
| clk_count | output | CNT_W | Running clock counter |

## Verification
The assertions assume that every descriptor field is known on any cycle where `in_valid` is high, and that `clr` and `in_valid` are never X after reset. The stimulus drives every field on each strobe and returns the strobe and clear to zero between transactions. This keeps the "no strobe" cycles well defined. Reserved kind codes and address forms 6 and 7 are sent only in transactions that are meant to be unsupported.

// File: rtl/ccost_pkg.sv
package ccost_pkg;
  localparam logic [1:0] K_REG = 2'd0;
  localparam logic [1:0] K_IMM = 2'd1;
  localparam logic [1:0] K_MEM = 2'd2;

  localparam logic [2:0] A_ONE    = 3'd0;
  localparam logic [2:0] A_DIRECT = 3'd1;
  localparam logic [2:0] A_BXSI   = 3'd2;
  localparam logic [2:0] A_BXDI   = 3'd3;
  localparam logic [2:0] A_BPSI   = 3'd4;
  localparam logic [2:0] A_BPDI   = 3'd5;

  typedef struct packed {
    logic       mem_used;
    logic [1:0] xfers;
    logic       bad;
  } base_info_t;
endpackage

// File: rtl/ccost_base.sv
module ccost_base
  import ccost_pkg::*;
#(
  parameter int CLK_W = 6
) (
  input  logic             op_add,
  input  logic [1:0]       dst_kind,
  input  logic [1:0]       src_kind,
  output logic [CLK_W-1:0] base,
  output base_info_t       info
);
  always_comb begin
    base = '0;
    info = '{mem_used: 1'b0, xfers: 2'd0, bad: 1'b0};
    if (!op_add) begin
      if (dst_kind == K_REG && src_kind == K_IMM)      base = CLK_W'(4);
      else if (dst_kind == K_REG && src_kind == K_REG) base = CLK_W'(2);
      else if (dst_kind == K_REG && src_kind == K_MEM) begin
        base = CLK_W'(8); info.mem_used = 1'b1; info.xfers = 2'd1;
      end else if (dst_kind == K_MEM && src_kind == K_REG) begin
        base = CLK_W'(9); info.mem_used = 1'b1; info.xfers = 2'd1;
      end else info.bad = 1'b1;
    end else begin
      if (dst_kind == K_REG && src_kind == K_REG)      base = CLK_W'(3);
      else if (dst_kind == K_REG && src_kind == K_IMM) base = CLK_W'(4);
      else if (dst_kind == K_REG && src_kind == K_MEM) begin
        base = CLK_W'(9); info.mem_used = 1'b1; info.xfers = 2'd1;
      end else if (dst_kind == K_MEM && src_kind == K_REG) begin
        base = CLK_W'(16); info.mem_used = 1'b1; info.xfers = 2'd2;
      end else if (dst_kind == K_MEM && src_kind == K_IMM) begin
        base = CLK_W'(17); info.mem_used = 1'b1; info.xfers = 2'd2;
      end else info.bad = 1'b1;
    end
  end
endmodule

// File: rtl/ccost_ea.sv
module ccost_ea
  import ccost_pkg::*;
#(
  parameter int CLK_W = 6
) (
  input  logic             mem_used,
  input  logic [2:0]       addr_form,
  input  logic             has_disp,
  output logic [CLK_W-1:0] ea,
  output logic             bad
);
  always_comb begin
    ea  = '0;
    bad = 1'b0;
    if (mem_used) begin
      case (addr_form)
        A_ONE:           ea = has_disp ? CLK_W'(9)  : CLK_W'(5);
        A_DIRECT:        ea = CLK_W'(6);
        A_BXSI, A_BPDI:  ea = has_disp ? CLK_W'(11) : CLK_W'(7);
        A_BXDI, A_BPSI:  ea = has_disp ? CLK_W'(12) : CLK_W'(8);
        default:         bad = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ccost_penalty.sv
module ccost_penalty #(
  parameter int CLK_W    = 6,
  parameter int XFER_CLK = 4
) (
  input  logic [1:0]       xfers,
  input  logic             is_word,
  input  logic             addr_odd,
  input  logic             bus8,
  output logic [CLK_W-1:0] pen
);
  logic pays;
  always_comb begin
    pays = is_word && (bus8 || addr_odd);
    pen  = pays ? CLK_W'(XFER_CLK * int'(xfers)) : '0;
  end
endmodule

// File: rtl/instr_clock_meter.sv
module instr_clock_meter
  import ccost_pkg::*;
#(
  parameter int CLK_W    = 6,
  parameter int CNT_W    = 32,
  parameter int XFER_CLK = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_valid,
  input  logic             op_add,
  input  logic [1:0]       dst_kind,
  input  logic [1:0]       src_kind,
  input  logic [2:0]       addr_form,
  input  logic             has_disp,
  input  logic             is_word,
  input  logic             addr_odd,
  input  logic             bus8,
  output logic             out_valid,
  output logic [CLK_W-1:0] base_clk,
  output logic [CLK_W-1:0] ea_clk,
  output logic [CLK_W-1:0] pen_clk,
  output logic [CLK_W-1:0] total_clk,
  output logic             unsupported,
  output logic [CNT_W-1:0] clk_count
);
  logic [CLK_W-1:0] b_c, e_c, p_c, t_c;
  logic             e_bad, unsup_c;
  base_info_t       binfo;

  ccost_base #(.CLK_W(CLK_W)) u_base (
    .op_add(op_add), .dst_kind(dst_kind), .src_kind(src_kind),
    .base(b_c), .info(binfo));

  ccost_ea #(.CLK_W(CLK_W)) u_ea (
    .mem_used(binfo.mem_used), .addr_form(addr_form), .has_disp(has_disp),
    .ea(e_c), .bad(e_bad));

  ccost_penalty #(.CLK_W(CLK_W), .XFER_CLK(XFER_CLK)) u_pen (
    .xfers(binfo.xfers), .is_word(is_word), .addr_odd(addr_odd),
    .bus8(bus8), .pen(p_c));

  always_comb begin
    unsup_c = binfo.bad | e_bad;
    t_c     = unsup_c ? '0 : (b_c + e_c + p_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      base_clk    <= '0;
      ea_clk      <= '0;
      pen_clk     <= '0;
      total_clk   <= '0;
      unsupported <= 1'b0;
      clk_count   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        base_clk    <= unsup_c ? '0 : b_c;
        ea_clk      <= unsup_c ? '0 : e_c;
        pen_clk     <= unsup_c ? '0 : p_c;
        total_clk   <= t_c;
        unsupported <= unsup_c;
      end
      if (clr)
        clk_count <= '0;
      else if (in_valid && !unsup_c)
        clk_count <= clk_count + CNT_W'(t_c);
    end
  end

  // R8: result strobe follows the input strobe by one cycle
  assert_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R11: rejected descriptor reports zero cost
  assert_unsup_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && unsupported) |-> (total_clk == '0 && pen_clk == '0));
  // R11: rejected descriptor leaves counter alone
  assert_unsup_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !clr && unsup_c) |=> $stable(clk_count));
  // R7: byte operations never pay a bus penalty
  assert_byte_nopen_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_word) |=> (pen_clk == '0));
  // R5: no memory operand means no addressing or penalty cost
  assert_regonly_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dst_kind != K_MEM && src_kind != K_MEM) |=> (ea_clk == '0 && pen_clk == '0));
  // R10: clear empties the counter
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (clk_count == '0));
  // R9: counter holds without a strobe
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clr) |=> $stable(clk_count));
endmodule

// File: tb/sim_instr_clock_meter.sv
module sim_instr_clock_meter;
  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, in_valid = 1'b0;
  logic op_add = 1'b0, has_disp = 1'b0, is_word = 1'b0, addr_odd = 1'b0, bus8 = 1'b0;
  logic [1:0] dst_kind = '0, src_kind = '0;
  logic [2:0] addr_form = '0;
  logic out_valid, unsupported;
  logic [5:0] base_clk, ea_clk, pen_clk, total_clk;
  logic [31:0] clk_count;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] model_cnt = 0;

  typedef struct {
    int b; int e; int p; int t; bit u; logic [31:0] cnt; string tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  instr_clock_meter u0 (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .op_add(op_add),
    .dst_kind(dst_kind), .src_kind(src_kind), .addr_form(addr_form),
    .has_disp(has_disp), .is_word(is_word), .addr_odd(addr_odd), .bus8(bus8),
    .out_valid(out_valid), .base_clk(base_clk), .ea_clk(ea_clk),
    .pen_clk(pen_clk), .total_clk(total_clk), .unsupported(unsupported),
    .clk_count(clk_count));

  function automatic void model(input bit a, input int d, input int s, input int f,
                                input bit dp, input bit w, input bit od, input bit n8,
                                output int b, output int e, output int p, output bit u);
    int x;
    b = 0; e = 0; p = 0; u = 0; x = 0;
    if (!a) begin
      if (d == 0 && s == 1) b = 4;
      else if (d == 0 && s == 0) b = 2;
      else if (d == 0 && s == 2) begin b = 8; x = 1; end
      else if (d == 2 && s == 0) begin b = 9; x = 1; end
      else u = 1;
    end else begin
      if (d == 0 && s == 0) b = 3;
      else if (d == 0 && s == 1) b = 4;
      else if (d == 0 && s == 2) begin b = 9; x = 1; end
      else if (d == 2 && s == 0) begin b = 16; x = 2; end
      else if (d == 2 && s == 1) begin b = 17; x = 2; end
      else u = 1;
    end
    if (x > 0) begin
      case (f)
        0: e = dp ? 9 : 5;
        1: e = 6;
        2, 5: e = dp ? 11 : 7;
        3, 4: e = dp ? 12 : 8;
        default: u = 1;
      endcase
      if (w && (n8 || od)) p = 4 * x;
    end
    if (u) begin b = 0; e = 0; p = 0; end
  endfunction

  task automatic send(input string tag, input bit a, input int d, input int s, input int f,
                      input bit dp, input bit w, input bit od, input bit n8, input bit c);
    exp_t it;
    @(negedge clk);
    op_add = a; dst_kind = 2'(d); src_kind = 2'(s); addr_form = 3'(f);
    has_disp = dp; is_word = w; addr_odd = od; bus8 = n8; clr = c; in_valid = 1'b1;
    model(a, d, s, f, dp, w, od, n8, it.b, it.e, it.p, it.u);
    it.t = it.b + it.e + it.p;
    if (c) model_cnt = 0;
    else if (!it.u) model_cnt = model_cnt + 32'(it.t);
    it.cnt = model_cnt; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t it;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R8: out_valid with nothing expected (actual 1, expected 0)");
      end else begin
        it = sb.pop_front();
        if (int'(base_clk) != it.b || int'(ea_clk) != it.e || int'(pen_clk) != it.p ||
            int'(total_clk) != it.t || unsupported != it.u || clk_count != it.cnt) begin
          errors++;
          $display("FAIL %s: actual b=%0d e=%0d p=%0d t=%0d u=%0d cnt=%0d expected b=%0d e=%0d p=%0d t=%0d u=%0d cnt=%0d",
                   it.tag, base_clk, ea_clk, pen_clk, total_clk, unsupported, clk_count,
                   it.b, it.e, it.p, it.t, it.u, it.cnt);
        end
      end
    end
  end

  task automatic check_cnt(input string tag, input logic [31:0] exp);
    checks++;
    if (clk_count !== exp) begin
      errors++;
      $display("FAIL %s: clk_count actual %0d expected %0d", tag, clk_count, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_cnt("R9 reset", 0);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R8 reset: out_valid actual %0b expected 0", out_valid);
    end
    // R1 move forms
    send("R1 mov r,imm", 0, 0, 1, 0, 0, 1, 0, 1, 0);
    send("R1 mov r,r",   0, 0, 0, 0, 0, 1, 0, 1, 0);
    send("R1 mov r,[m]", 0, 0, 2, 0, 0, 1, 0, 1, 0);
    send("R1 mov [m],r", 0, 2, 0, 2, 1, 0, 0, 1, 0);
    // R2 add forms
    send("R2 add r,r",   1, 0, 0, 0, 0, 1, 1, 1, 0);
    send("R2 add r,imm", 1, 0, 1, 0, 0, 1, 0, 0, 0);
    send("R2 add r,[m]", 1, 0, 2, 4, 1, 1, 0, 0, 0);
    send("R2 add [m],r", 1, 2, 0, 0, 1, 1, 0, 1, 0);
    send("R2 add [m],i", 1, 2, 1, 4, 0, 1, 0, 1, 0);
    // R3 pair forms
    send("R3 bp+di",     0, 0, 2, 5, 0, 0, 0, 0, 0);
    send("R3 bx+di d",   0, 0, 2, 3, 1, 0, 0, 0, 0);
    send("R3 bx+si",     1, 2, 1, 2, 0, 0, 1, 0, 0);
    send("R3 bp+di d",   0, 2, 0, 5, 1, 0, 0, 0, 0);
    // R4 single and direct
    send("R4 direct",    0, 0, 2, 1, 1, 0, 0, 0, 0);
    send("R4 one d",     1, 0, 2, 0, 1, 0, 0, 0, 0);
    // R5 reg-only with odd/narrow set
    send("R5 add r,imm", 1, 0, 1, 3, 1, 1, 1, 1, 0);
    // R6 narrow bus
    send("R6 rmw 8",     1, 2, 0, 1, 0, 1, 0, 1, 0);
    send("R6 read 4",    1, 0, 2, 1, 0, 1, 1, 1, 0);
    send("R6 byte",      1, 2, 1, 1, 0, 0, 1, 1, 0);
    // R7 wide bus
    send("R7 odd rmw",   1, 2, 0, 2, 0, 1, 1, 0, 0);
    send("R7 odd rd",    0, 0, 2, 3, 0, 1, 1, 0, 0);
    send("R7 even",      1, 2, 1, 3, 1, 1, 0, 0, 0);
    send("R7 odd byte",  1, 2, 1, 3, 1, 0, 1, 0, 0);
    // R11 rejected descriptors
    send("R11 imm dst",  0, 1, 0, 0, 0, 1, 0, 1, 0);
    send("R11 mem-mem",  1, 2, 2, 0, 0, 1, 0, 1, 0);
    send("R11 mov m,i",  0, 2, 1, 0, 0, 1, 0, 1, 0);
    send("R11 form6",    0, 0, 2, 6, 0, 1, 0, 1, 0);
    send("R11 kind3",    1, 0, 3, 0, 0, 1, 0, 1, 0);
    // R9 hold over idle cycles
    repeat (3) @(negedge clk);
    check_cnt("R9 hold", model_cnt);
    // R10 clear alone
    @(negedge clk); clr = 1'b1; model_cnt = 0;
    @(negedge clk); clr = 1'b0;
    check_cnt("R10 clear", 0);
    send("R9 accum",     0, 0, 2, 0, 0, 1, 0, 1, 0);
    send("R9 accum2",    1, 2, 0, 4, 1, 1, 0, 1, 0);
    // R10 clear together with a strobe
    send("R10 clr+valid", 1, 2, 1, 4, 1, 1, 0, 1, 1);
    send("R9 after clr", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R8: %0d results missing (expected 0)", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule